// File: doc/BRIEF.md
# Differencing Multistage Interference Canceller Stage

One stage of a parallel interference cancellation detector for a synchronous multiuser spread-spectrum uplink with eight users. The stage receives the matched-filter outputs, the current interference estimate for every user and two decision vectors: the decisions formed by the stage before it and the decisions that stage started from. Each user's interference estimate is corrected from the change between those two vectors, scaled by a cross-correlation matrix that is written once per frame and kept across all stages and symbols. The stage then produces new soft outputs, hard decisions and the updated interference estimate.

A decision is +1, -1 or 0, so a change in a decision is one of -2, -1, 0, +1 or +2. Each change is recoded into an operation for a shift/add unit: skip, add or subtract the correlation, or add or subtract the correlation shifted left by one. This replaces every multiply. The datapath steps at half the input clock rate. It works through users 0 to 7 in order, with eight steps per user, one for each interferer column. The diagonal column is always skipped. Stages chain through a valid/ready handshake. A strap marks the last stage, which raises an output-valid flag in place of the load strobe to a further stage. The first stage is given all-zero previous decisions and a zero interference estimate, so it performs a full conventional cancellation.

Top module: `pic_stage`

## Requirements
- R1: Writing `corr_data_i` with `corr_we_i` high stores it at row `corr_row_i` (victim user) and column `corr_col_i` (interfering user). The value is used by every later run until it is overwritten.
- R2: Decision codes are 2 bits per user, user u in bits [2u+1:2u]: 01 means +1, 11 means -1, 00 means 0. `intf_o` for user k equals `intf_i[k]` + the sum over j≠k of corr[k][j]·(cur_j − prev_j), held in 16-bit signed form.
- R3: The diagonal entry corr[k][k] has no effect on any output.
- R4: `soft_o` for user k is `mf_i[k]` − `intf_o[k]`, saturated to the range −2048..2047.
- R5: `dec_o` for user k is 01 when its soft output is ≥ 0 and 11 when it is negative.
- R6: `mf_o` repeats the accepted `mf_i`, and `dec_prev_o` repeats the accepted `dec_cur_i`, for the next stage.
- R7: An input set is accepted on a clock edge only when `ld_i` and `rdy_o` are both high. `rdy_o` is high only while the stage is idle, so `ld_i` has no effect while a run is in progress or a result is waiting.
- R8: A finished result stays stable on the outputs until `take_i` is seen high. After that edge `rdy_o` is high again.
- R9: With `last_stage_i` low, a finished result raises `ld_o`. With it high, the result raises `out_valid_o` instead. The two are never high together.
- R10: The result appears 127 or 128 clock cycles after the accepting edge: 64 shift/add steps at half the clock rate.
- R11: After reset, `rdy_o` is 1, `ld_o` and `out_valid_o` are 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| corr_we_i | input | 1 | Correlation write strobe |
| corr_row_i | input | 3 | Correlation row (victim user) |
| corr_col_i | input | 3 | Correlation column (interfering user) |
| corr_data_i | input | 12 | Correlation value, signed |
| ld_i | input | 1 | Upstream load strobe (inputs valid) |
| rdy_o | output | 1 | Stage idle, able to accept |
| mf_i | input | 96 | Matched-filter outputs, 12 bits per user |
| intf_i | input | 128 | Interference estimates, 16 bits per user |
| dec_cur_i | input | 16 | Current decisions, 2 bits per user |
| dec_prev_i | input | 16 | Previous decisions, 2 bits per user |
| last_stage_i | input | 1 | Strap: this stage ends the cascade |
| take_i | input | 1 | Downstream takes the result |
| ld_o | output | 1 | Load strobe to the next stage |
| out_valid_o | output | 1 | Final result valid (last stage only) |
| mf_o | output | 96 | Forwarded matched-filter outputs |
| intf_o | output | 128 | Updated interference estimates |
| soft_o | output | 96 | Soft outputs, 12 bits per user |
| dec_o | output | 16 | Hard decisions |
| dec_prev_o | output | 16 | Forwarded current decisions |

## Verification
The first run uses all-zero previous decisions, so every change is ±1 and only the unshifted add and subtract paths are used. Feeding each result back as the next stage's input then produces changes of ±2 and 0, which exercise the shifted paths and the skip code. Rewriting only the diagonal and repeating an identical input separates a correct diagonal skip from a design that sums the full row. Uniform full-scale correlations with all decisions at +1, and then at −1, drive the soft result past both ends of its range, which tells saturation apart from wrap-around.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {OP_SKIP, OP_ADD1, OP_SUB1, OP_ADD2, OP_SUB2} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
endpackage

// File: rtl/pic_corr_store.sv
module pic_corr_store #(
  parameter int N_USR = 8,
  parameter int DW    = 12,
  localparam int UW   = $clog2(N_USR)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [UW-1:0]        wrow_i,
  input  logic [UW-1:0]        wcol_i,
  input  logic signed [DW-1:0] wdata_i,
  input  logic [UW-1:0]        rrow_i,
  input  logic [UW-1:0]        rcol_i,
  output logic signed [DW-1:0] rdata_o
);
  logic signed [DW-1:0] mem_q [N_USR][N_USR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_USR; r++)
        for (int c = 0; c < N_USR; c++)
          mem_q[r][c] <= '0;
    end else if (we_i) begin
      mem_q[wrow_i][wcol_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[rrow_i][rcol_i];

  // R1: a write lands at its row/column
  a_r1_corr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(wrow_i)][$past(wcol_i)] == $past(wdata_i)));
endmodule

// File: rtl/pic_recoder.sv
module pic_recoder
  import pic_pkg::*;
(
  input  logic [1:0] cur_i,
  input  logic [1:0] prev_i,
  input  logic       diag_i,
  output op_e        op_o
);
  function automatic logic signed [2:0] dec_val(input logic [1:0] c);
    case (c)
      2'b01:   return 3'sd1;
      2'b11:   return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  logic signed [2:0] diff;
  assign diff = dec_val(cur_i) - dec_val(prev_i);

  always_comb begin
    op_o = OP_SKIP;
    if (!diag_i) begin
      case (diff)
        3'sd1:   op_o = OP_ADD1;
        -3'sd1:  op_o = OP_SUB1;
        3'sd2:   op_o = OP_ADD2;
        -3'sd2:  op_o = OP_SUB2;
        default: op_o = OP_SKIP;
      endcase
    end
  end
endmodule

// File: rtl/pic_shift_alu.sv
module pic_shift_alu
  import pic_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = DW + 4
) (
  input  logic signed [AW-1:0] acc_i,
  input  logic signed [DW-1:0] corr_i,
  input  op_e                  op_i,
  output logic signed [AW-1:0] acc_o
);
  logic signed [AW-1:0] ext, ext_sh;
  assign ext    = {{(AW-DW){corr_i[DW-1]}}, corr_i};
  assign ext_sh = ext <<< 1;

  always_comb begin
    case (op_i)
      OP_ADD1: acc_o = acc_i + ext;
      OP_SUB1: acc_o = acc_i - ext;
      OP_ADD2: acc_o = acc_i + ext_sh;
      OP_SUB2: acc_o = acc_i - ext_sh;
      default: acc_o = acc_i;
    endcase
  end
endmodule

// File: rtl/pic_stage.sv
module pic_stage
  import pic_pkg::*;
#(
  parameter int N_USR = 8,
  parameter int DW    = 12,
  parameter int AW    = DW + 4,
  localparam int UW   = $clog2(N_USR)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                corr_we_i,
  input  logic [UW-1:0]       corr_row_i,
  input  logic [UW-1:0]       corr_col_i,
  input  logic [DW-1:0]       corr_data_i,
  input  logic                ld_i,
  output logic                rdy_o,
  input  logic [N_USR*DW-1:0] mf_i,
  input  logic [N_USR*AW-1:0] intf_i,
  input  logic [2*N_USR-1:0]  dec_cur_i,
  input  logic [2*N_USR-1:0]  dec_prev_i,
  input  logic                last_stage_i,
  input  logic                take_i,
  output logic                ld_o,
  output logic                out_valid_o,
  output logic [N_USR*DW-1:0] mf_o,
  output logic [N_USR*AW-1:0] intf_o,
  output logic [N_USR*DW-1:0] soft_o,
  output logic [2*N_USR-1:0]  dec_o,
  output logic [2*N_USR-1:0]  dec_prev_o
);
  localparam logic signed [AW:0] SMAX = (AW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [AW:0] SMIN = ~SMAX;
  localparam logic [UW-1:0]      ULAST = UW'(N_USR-1);

  st_e                  st_q;
  logic                 ph_q;
  logic [UW-1:0]        k_q, j_q, k_nxt;
  logic signed [AW-1:0] acc_q, acc_nxt;
  logic [N_USR*DW-1:0]  mf_q, soft_q;
  logic [N_USR*AW-1:0]  intf_in_q, intfo_q;
  logic [2*N_USR-1:0]   cur_q, prev_q, dec_q;
  logic signed [DW-1:0] corr_rd;
  op_e                  op;
  logic signed [AW:0]   diff;
  logic signed [DW-1:0] soft_val;
  logic                 tick, accept;

  pic_corr_store #(.N_USR(N_USR), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .we_i(corr_we_i), .wrow_i(corr_row_i), .wcol_i(corr_col_i),
    .wdata_i(corr_data_i), .rrow_i(k_q), .rcol_i(j_q), .rdata_o(corr_rd)
  );

  // recoding of column j overlaps the fetch of its correlation
  pic_recoder u_rec (
    .cur_i(cur_q[2*j_q +: 2]), .prev_i(prev_q[2*j_q +: 2]),
    .diag_i(j_q == k_q), .op_o(op)
  );

  pic_shift_alu #(.DW(DW), .AW(AW)) u_alu (
    .acc_i(acc_q), .corr_i(corr_rd), .op_i(op), .acc_o(acc_nxt)
  );

  always_comb begin
    diff = {{(AW+1-DW){mf_q[k_q*DW+DW-1]}}, mf_q[k_q*DW +: DW]}
         - {acc_nxt[AW-1], acc_nxt};
    if (diff > SMAX)      soft_val = SMAX[DW-1:0];
    else if (diff < SMIN) soft_val = SMIN[DW-1:0];
    else                  soft_val = diff[DW-1:0];
  end

  assign k_nxt  = k_q + 1'b1;
  assign tick   = ph_q && (st_q == ST_RUN);
  assign accept = ld_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= 1'b0;
      k_q       <= '0;
      j_q       <= '0;
      acc_q     <= '0;
      mf_q      <= '0;
      intf_in_q <= '0;
      cur_q     <= '0;
      prev_q    <= '0;
      soft_q    <= '0;
      intfo_q   <= '0;
      dec_q     <= '0;
    end else begin
      ph_q <= ~ph_q;  // half-rate datapath enable
      case (st_q)
        ST_IDLE: if (accept) begin
          mf_q      <= mf_i;
          intf_in_q <= intf_i;
          cur_q     <= dec_cur_i;
          prev_q    <= dec_prev_i;
          acc_q     <= intf_i[AW-1:0];
          k_q       <= '0;
          j_q       <= '0;
          st_q      <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          if (j_q == ULAST) begin
            soft_q[k_q*DW +: DW]  <= soft_val;
            intfo_q[k_q*AW +: AW] <= acc_nxt;
            dec_q[2*k_q +: 2]     <= soft_val[DW-1] ? 2'b11 : 2'b01;
            j_q                   <= '0;
            k_q                   <= k_nxt;
            acc_q                 <= intf_in_q[k_nxt*AW +: AW];
            if (k_q == ULAST) st_q <= ST_DONE;
          end else begin
            acc_q <= acc_nxt;
            j_q   <= j_q + 1'b1;
          end
        end
        ST_DONE: if (take_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rdy_o       = (st_q == ST_IDLE);
  assign ld_o        = (st_q == ST_DONE) && !last_stage_i;
  assign out_valid_o = (st_q == ST_DONE) && last_stage_i;
  assign mf_o        = mf_q;
  assign intf_o      = intfo_q;
  assign soft_o      = soft_q;
  assign dec_o       = dec_q;
  assign dec_prev_o  = cur_q;

  // R7: accepting leaves the idle state
  a_r7_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && ld_i) |=> !rdy_o);
  // R8: result held until taken
  a_r8_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ld_o || out_valid_o) && !take_i) |=> ($stable(soft_o) && $stable(dec_o) && $stable(intf_o)));
  // R10: datapath advances only on alternate cycles
  a_r10_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !ph_q) |=> ($stable(acc_q) && $stable(j_q)));
  // R9: strobe routing is exclusive
  a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_o && out_valid_o));

  for (genvar u = 0; u < N_USR; u++) begin : g_chk
    // R5: decision agrees with soft sign once done
    a_r5_dec_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_DONE) |-> (dec_q[2*u +: 2] == (soft_q[u*DW+DW-1] ? 2'b11 : 2'b01)));
  end
endmodule

// File: tb/pic_stage_tb.sv
module pic_stage_tb;
  localparam int N = 8, DW = 12, AW = 16;

  logic clk = 0, rst_n = 0;
  logic corr_we = 0;
  logic [2:0] corr_row = 0, corr_col = 0;
  logic [DW-1:0] corr_data = 0;
  logic ld = 0, take = 0, last = 0;
  logic [N*DW-1:0] mf_v = 0;
  logic [N*AW-1:0] intf_v = 0;
  logic [2*N-1:0] cur_v = 0, prev_v = 0;
  logic rdy, ld_out, oval;
  logic [N*DW-1:0] mf_o, soft_o;
  logic [N*AW-1:0] intf_o;
  logic [2*N-1:0] dec_o, dprev_o;

  int checks = 0, errs = 0;
  int r[N][N];
  int mf[N], intf[N], cur[N], prev[N];
  int e_intf[N], e_soft[N], e_dec[N];
  bit exp_idle = 1;

  always #10 clk = ~clk;

  pic_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .corr_we_i(corr_we), .corr_row_i(corr_row),
    .corr_col_i(corr_col), .corr_data_i(corr_data), .ld_i(ld), .rdy_o(rdy),
    .mf_i(mf_v), .intf_i(intf_v), .dec_cur_i(cur_v), .dec_prev_i(prev_v),
    .last_stage_i(last), .take_i(take), .ld_o(ld_out), .out_valid_o(oval),
    .mf_o(mf_o), .intf_o(intf_o), .soft_o(soft_o), .dec_o(dec_o), .dec_prev_o(dprev_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input int d);
    return (d > 0) ? 2'b01 : (d < 0) ? 2'b11 : 2'b00;
  endfunction

  // cycle model of the handshake, compared on every clock
  always @(posedge clk) begin
    if (!rst_n) exp_idle = 1;
    else if (exp_idle && ld) exp_idle = 0;
    else if (!exp_idle && take && (ld_out || oval)) exp_idle = 1;
  end
  always @(negedge clk) if (rst_n) begin
    if (rdy !== exp_idle) begin
      checks++; errs++;
      $display("FAIL R7/R8 rdy_o actual=%0d expected=%0d", rdy, exp_idle);
    end
    if (ld_out && oval) begin
      checks++; errs++;
      $display("FAIL R9 both strobes actual=1 expected=0");
    end
  end

  task automatic wr_corr(input int k, input int j, input int v);
    @(negedge clk);
    corr_we = 1; corr_row = 3'(k); corr_col = 3'(j); corr_data = DW'(v);
    @(negedge clk);
    corr_we = 0;
  endtask

  task automatic compute_ref();
    for (int k = 0; k < N; k++) begin
      int s = intf[k];
      int d;
      for (int j = 0; j < N; j++) if (j != k) s += r[k][j] * (cur[j] - prev[j]);
      e_intf[k] = s;
      d = mf[k] - s;
      if (d > 2047) d = 2047;
      if (d < -2048) d = -2048;
      e_soft[k] = d;
      e_dec[k] = (d < 0) ? -1 : 1;
    end
  endtask

  task automatic check_out(input string tag);
    for (int k = 0; k < N; k++) begin
      chk($signed(intf_o[k*AW +: AW]) == e_intf[k], {tag, " R2 intf"}, $signed(intf_o[k*AW +: AW]), e_intf[k]);
      chk($signed(soft_o[k*DW +: DW]) == e_soft[k], {tag, " R4 soft"}, $signed(soft_o[k*DW +: DW]), e_soft[k]);
      chk(dec_o[2*k +: 2] == enc(e_dec[k]), {tag, " R5 dec"}, dec_o[2*k +: 2], enc(e_dec[k]));
      chk($signed(mf_o[k*DW +: DW]) == mf[k], {tag, " R6 mf pass"}, $signed(mf_o[k*DW +: DW]), mf[k]);
      chk(dprev_o[2*k +: 2] == enc(cur[k]), {tag, " R6 dec pass"}, dprev_o[2*k +: 2], enc(cur[k]));
    end
  endtask

  // hold > 0: keep result untaken, push ignored loads meanwhile
  task automatic run_stage(input string tag, input bit is_last, input int hold);
    int n = 0;
    last = is_last;
    compute_ref();
    for (int k = 0; k < N; k++) begin
      mf_v[k*DW +: DW] = DW'(mf[k]);
      intf_v[k*AW +: AW] = AW'(intf[k]);
      cur_v[2*k +: 2] = enc(cur[k]);
      prev_v[2*k +: 2] = enc(prev[k]);
    end
    @(negedge clk);
    while (!rdy) @(negedge clk);
    ld = 1;
    @(negedge clk);
    ld = 0;
    while (!(ld_out || oval) && n < 400) begin @(negedge clk); n++; end
    chk(n == 127 || n == 128, {tag, " R10 latency"}, n, 127);
    chk(ld_out == !is_last && oval == is_last, {tag, " R9 strobe"}, {ld_out, oval}, is_last ? 1 : 2);
    check_out(tag);
    if (hold > 0) begin
      ld = 1; mf_v = ~mf_v; cur_v = ~cur_v;
      repeat (hold) @(negedge clk);
      chk(rdy == 0, {tag, " R7 busy while held"}, rdy, 0);
      check_out({tag, " R8 held"});
    end
    ld = 0; take = 1;
    @(negedge clk);
    take = 0;
    chk(rdy == 1, {tag, " R8 ready after take"}, rdy, 1);
    if (hold > 0) check_out({tag, " R7 load ignored"});
  endtask

  task automatic feed_back();
    for (int k = 0; k < N; k++) begin
      prev[k] = cur[k]; cur[k] = e_dec[k]; intf[k] = e_intf[k];
    end
  endtask

  task automatic first_stage_setup(input int seed);
    for (int k = 0; k < N; k++) begin
      mf[k] = ((k * 613 + seed * 97) % 3001) - 1500;
      intf[k] = 0; prev[k] = 0;
      cur[k] = (mf[k] < 0) ? -1 : 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(rdy == 1, "R11 rdy", rdy, 1);
    chk(ld_out == 0 && oval == 0, "R11 strobes", {ld_out, oval}, 0);
    chk(soft_o == 0 && intf_o == 0 && dec_o == 0, "R11 results", 0, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: load matrix once; diagonal deliberately large
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++) begin
        r[k][j] = (k == j) ? 2047 : ((k * 37 + j * 53) % 401) - 200;
        wr_corr(k, j, r[k][j]);
      end

    // three-stage cascade through one stage, no reload (R1, R2)
    first_stage_setup(1);
    run_stage("s1", 0, 0);
    feed_back();
    run_stage("s2", 0, 0);
    feed_back();
    run_stage("s3 R1 reuse", 1, 0);

    // R3: change only the diagonal, repeat first stage
    for (int k = 0; k < N; k++) wr_corr(k, k, -1000 + k * 7);
    first_stage_setup(1);
    run_stage("R3 diag", 0, 0);

    // second pattern with hold and ignored loads (R7, R8)
    first_stage_setup(5);
    run_stage("hold", 0, 12);
    feed_back();
    run_stage("hold s2", 1, 0);

    // R4: saturation both ways
    for (int k = 0; k < N; k++)
      for (int j = 0; j < N; j++) if (j != k) begin
        r[k][j] = 2047;
        wr_corr(k, j, 2047);
      end
    for (int k = 0; k < N; k++) begin mf[k] = 2000 - k; intf[k] = 0; prev[k] = 0; cur[k] = -1; end
    run_stage("R4 sat hi", 0, 0);
    for (int k = 0; k < N; k++) begin mf[k] = -2000 + k; cur[k] = 1; end
    run_stage("R4 sat lo", 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule